// File: doc/BRIEF.md
# External Memory Sizing Engine

This block runs once after reset. It finds out how much contiguous working RAM sits on a byte-wide external data port. It starts at address zero and moves up one location at a time. At each location it writes a nonzero marker byte and reads it back. If the marker comes back intact, it writes zero to the same location and reads that back. The first location that fails either check ends the scan. The address just below that location is the top of usable memory.

The scan never enters the reserved upper window above a configurable limit. If every location up to the limit passes, the limit itself is reported as the top. When fewer locations than a configured minimum pass, the engine does not signal completion. Instead it raises an insufficient-memory status and parks in a halt state until the next reset. Boot logic waits for either the completion pulse or the status bit before it uses the reported top.

The memory port is simple and synchronous. Write data is taken on the clock edge that ends a write-strobe cycle. Read data is registered by the memory and is presented in the cycle after the read-strobe cycle.

Top module: `memsize_probe`

## Requirements
- R1: While reset is asserted, and directly after it, `mem_top` is 0 and `done`, `insuff`, `mem_we` and `mem_re` are all 0.
- R2: Probing starts at address 0 and moves up by exactly one address per probe. Each probe begins with a write of the marker `MARKER` (default 5Ah) to the probed address.
- R3: At each address, a read of the same address follows the marker write. If that read returns the marker, a write of 00h to the same address follows, and then another read of that address.
- R4: Each probe has eight cycles in a fixed order: marker write, wait, read strobe, compare, zero write, wait, read strobe, compare. Write and read strobes are never active together. Count the cycles as the number of clock edges after reset release. A marker failure at address F finishes on edge 8F+5. A zero failure at address F finishes on edge 8F+9.
- R5: The first failing address F ends the scan, and `mem_top` then reads F-1, wrapping to FFFFh when F is 0.
- R6: No strobe is ever issued to an address above `TOP_LIMIT` (default DFFFh). If every address up to `TOP_LIMIT` passes, `mem_top` reads `TOP_LIMIT`, and completion comes on edge 8·TOP_LIMIT+9.
- R7: If fewer than `MIN_BYTES` (default 1024) locations pass, `done` never asserts. `insuff` goes to 1 on the finishing edge and stays 1 until reset. No further strobes are issued while it is 1.
- R8: On a sufficient result, `done` is a one-cycle pulse on the finishing edge. After it, no more strobes are issued and `mem_top` holds its value.
- R9: Exactly `MIN_BYTES` passing locations counts as sufficient. One fewer does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_addr | output | ADDR_W | Probe address |
| mem_wdata | output | DATA_W | Write data, valid when mem_we is 1 |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe; data is expected on mem_rdata one cycle later |
| mem_rdata | input | DATA_W | Registered read data from the memory |
| mem_top | output | ADDR_W | Highest usable address, valid once done or insuff is 1 |
| done | output | 1 | One-cycle pulse when sizing finishes with enough memory |
| insuff | output | 1 | Sticky flag: less than MIN_BYTES of memory was found |

## Verification
The hardest cases to reach from the ports are a failure on the zero pass and a failure on the marker pass, because both need a location that behaves well for one pattern but not the other. The bench memory model injects a stuck-at-one mask at a chosen address. A mask on bit 0 spoils the marker. A mask on bit 1, which the marker already has set, lets the marker pass and spoils only the zero read-back. Running the scan all the way to the limit at the default DFFFh would be too long, so the bench lowers the limit parameter. It then checks the full-pass top, the window bound, and the sufficiency boundary at exactly one kilobyte and one byte short of it.

// File: rtl/memsize_pkg.sv
package memsize_pkg;

  // One state per probe phase, plus start and the terminal states.
  typedef enum logic [3:0] {
    ST_START = 4'd0,
    ST_WR_MK = 4'd1,
    ST_WT_MK = 4'd2,
    ST_RD_MK = 4'd3,
    ST_CK_MK = 4'd4,
    ST_WR_ZR = 4'd5,
    ST_WT_ZR = 4'd6,
    ST_RD_ZR = 4'd7,
    ST_CK_ZR = 4'd8,
    ST_DONE  = 4'd9,
    ST_IDLE  = 4'd10,
    ST_HALT  = 4'd11
  } probe_st_e;

endpackage

// File: rtl/memsize_addr.sv
module memsize_addr #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TOP_LIMIT = 16'hDFFF,
  parameter int                MIN_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_limit,
  output logic              enough
);

  localparam logic [ADDR_W:0] MIN_W = (ADDR_W+1)'(MIN_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (step) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (step) addr_q <= addr_d;
  end

  // The address of the first failure equals the count of passing bytes.
  assign addr     = addr_q;
  assign at_limit = (addr_q == TOP_LIMIT);
  assign enough   = ({1'b0, addr_q} >= MIN_W);

endmodule

// File: rtl/memsize_ctrl.sv
module memsize_ctrl
  import memsize_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] TOP_LIMIT = 16'hDFFF,
  parameter int                MIN_BYTES = 1024
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mismatch,
  input  logic      at_limit,
  input  logic      enough,
  output probe_st_e st,
  output logic      step,
  output logic      fin_fail,
  output logic      fin_full,
  output logic      halt_set
);

  localparam logic [ADDR_W:0] SPAN    = {1'b0, TOP_LIMIT} + 1'b1;
  localparam bit              FULL_OK = (SPAN >= (ADDR_W+1)'(MIN_BYTES));

  probe_st_e st_q;
  probe_st_e st_d;

  always_comb begin
    st_d     = st_q;
    step     = 1'b0;
    fin_fail = 1'b0;
    fin_full = 1'b0;
    halt_set = 1'b0;
    case (st_q)
      ST_START: st_d = ST_WR_MK;
      ST_WR_MK: st_d = ST_WT_MK;
      ST_WT_MK: st_d = ST_RD_MK;
      ST_RD_MK: st_d = ST_CK_MK;
      ST_CK_MK: begin
        if (mismatch) begin
          fin_fail = 1'b1;
          halt_set = !enough;
          st_d     = enough ? ST_DONE : ST_HALT;
        end else begin
          st_d = ST_WR_ZR;
        end
      end
      ST_WR_ZR: st_d = ST_WT_ZR;
      ST_WT_ZR: st_d = ST_RD_ZR;
      ST_RD_ZR: st_d = ST_CK_ZR;
      ST_CK_ZR: begin
        if (mismatch) begin
          fin_fail = 1'b1;
          halt_set = !enough;
          st_d     = enough ? ST_DONE : ST_HALT;
        end else if (at_limit) begin
          fin_full = 1'b1;
          halt_set = !FULL_OK;
          st_d     = FULL_OK ? ST_DONE : ST_HALT;
        end else begin
          step = 1'b1;
          st_d = ST_WR_MK;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_IDLE: st_d = ST_IDLE;
      ST_HALT: st_d = ST_HALT;
      default: st_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_START;
    else        st_q <= st_d;
  end

  assign st = st_q;

endmodule

// File: rtl/memsize_data.sv
module memsize_data
  import memsize_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] MARKER = 8'h5A
) (
  input  probe_st_e         st,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata,
  output logic              we,
  output logic              re,
  output logic              mismatch
);

  logic              in_check;
  logic [DATA_W-1:0] expect_v;

  always_comb begin
    we       = (st == ST_WR_MK) || (st == ST_WR_ZR);
    re       = (st == ST_RD_MK) || (st == ST_RD_ZR);
    wdata    = (st == ST_WR_MK) ? MARKER : '0;
    in_check = (st == ST_CK_MK) || (st == ST_CK_ZR);
    expect_v = (st == ST_CK_MK) ? MARKER : '0;
    mismatch = in_check && (rdata != expect_v);
  end

endmodule

// File: rtl/memsize_result.sv
module memsize_result #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_fail,
  input  logic              fin_full,
  input  logic              halt_set,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] top,
  output logic              insuff
);

  logic              load;
  logic [ADDR_W-1:0] top_d;
  logic [ADDR_W-1:0] top_q;
  logic              insuff_q;

  always_comb begin
    load  = fin_fail || fin_full;
    top_d = fin_full ? addr : (addr - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    top_q <= '0;
    else if (load) top_q <= top_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        insuff_q <= 1'b0;
    else if (halt_set) insuff_q <= 1'b1;
  end

  assign top    = top_q;
  assign insuff = insuff_q;

endmodule

// File: rtl/memsize_probe.sv
module memsize_probe
  import memsize_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] MARKER    = 8'h5A,
  parameter logic [ADDR_W-1:0] TOP_LIMIT = 16'hDFFF,
  parameter int                MIN_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_top,
  output logic              done,
  output logic              insuff
);

  probe_st_e         st;
  logic              step;
  logic              at_limit;
  logic              enough;
  logic              mismatch;
  logic              fin_fail;
  logic              fin_full;
  logic              halt_set;
  logic [ADDR_W-1:0] addr;

  memsize_addr #(
    .ADDR_W   (ADDR_W),
    .TOP_LIMIT(TOP_LIMIT),
    .MIN_BYTES(MIN_BYTES)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .addr    (addr),
    .at_limit(at_limit),
    .enough  (enough)
  );

  memsize_ctrl #(
    .ADDR_W   (ADDR_W),
    .TOP_LIMIT(TOP_LIMIT),
    .MIN_BYTES(MIN_BYTES)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .mismatch(mismatch),
    .at_limit(at_limit),
    .enough  (enough),
    .st      (st),
    .step    (step),
    .fin_fail(fin_fail),
    .fin_full(fin_full),
    .halt_set(halt_set)
  );

  memsize_data #(
    .DATA_W(DATA_W),
    .MARKER(MARKER)
  ) u_data (
    .st      (st),
    .rdata   (mem_rdata),
    .wdata   (mem_wdata),
    .we      (mem_we),
    .re      (mem_re),
    .mismatch(mismatch)
  );

  memsize_result #(
    .ADDR_W(ADDR_W)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n),
    .fin_fail(fin_fail),
    .fin_full(fin_full),
    .halt_set(halt_set),
    .addr    (addr),
    .top     (mem_top),
    .insuff  (insuff)
  );

  assign mem_addr = addr;
  assign done     = (st == ST_DONE);

endmodule

// File: rtl/memsize_probe_chk.sv
module memsize_probe_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] MARKER    = 8'h5A,
  parameter logic [ADDR_W-1:0] TOP_LIMIT = 16'hDFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_top,
  input logic              done,
  input logic              insuff
);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ($past(mem_we, 2) && ($past(mem_addr, 2) == mem_addr)));

  assert_zero_after_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_wdata == '0)) |->
      ($past(mem_we, 4) && ($past(mem_wdata, 4) == MARKER) && ($past(mem_addr, 4) == mem_addr)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_wdata == MARKER) && (mem_addr != '0)) |->
      ($past(mem_addr, 8) == (mem_addr - 1'b1)));

  assert_addr_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr <= TOP_LIMIT));

  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    insuff |=> (insuff && !done));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    insuff |-> (!mem_we && !mem_re));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !mem_we && !mem_re && $stable(mem_top)));

endmodule

bind memsize_probe memsize_probe_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MARKER   (MARKER),
  .TOP_LIMIT(TOP_LIMIT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_top  (mem_top),
  .done     (done),
  .insuff   (insuff)
);

// File: tb/memsize_probe_tb.sv
`timescale 1ns/1ps
module memsize_probe_tb;

  localparam int          AW   = 16;
  localparam int          DW   = 8;
  localparam logic [15:0] LIM  = 16'h0BFF;
  localparam int          MINB = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          mem_re;
  logic [DW-1:0] mem_rdata = 8'hFF;
  logic [AW-1:0] mem_top;
  logic          done;
  logic          insuff;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  memsize_probe #(
    .ADDR_W(AW), .DATA_W(DW), .MARKER(8'h5A), .TOP_LIMIT(LIM), .MIN_BYTES(MINB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .mem_top(mem_top), .done(done), .insuff(insuff)
  );

  // Memory model: pop_size populated bytes, unpopulated reads FFh,
  // optional stuck-at-one mask on one address.
  logic [7:0] store [0:4095];
  int         pop_size  = 0;
  int         flt_addr  = -1;
  logic [7:0] flt_mask  = 8'h00;
  int         max_addr  = 0;

  always @(posedge clk) begin
    if (mem_we && (int'(mem_addr) < pop_size))
      store[mem_addr[11:0]] <= mem_wdata;
    if (mem_re) begin
      if (int'(mem_addr) < pop_size)
        mem_rdata <= (int'(mem_addr) == flt_addr) ? (store[mem_addr[11:0]] | flt_mask)
                                                  : store[mem_addr[11:0]];
      else
        mem_rdata <= 8'hFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (mem_we || mem_re) && (int'(mem_addr) > max_addr))
      max_addr = int'(mem_addr);
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic start_run(input int size, input int faddr, input logic [7:0] fmask);
    rst_n    = 1'b0;
    pop_size = size;
    flt_addr = faddr;
    flt_mask = fmask;
    max_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: outputs while reset is held
  task automatic test_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "mem_top in reset", longint'(mem_top), 0);
    chk("R1", "done in reset", longint'(done), 0);
    chk("R1", "insuff in reset", longint'(insuff), 0);
    chk("R1", "strobes in reset", longint'({mem_we, mem_re}), 0);
  endtask

  // R2, R3, R4: the strobe pattern of the first probe and the start of the second
  task automatic test_first_probe();
    start_run(2048, -1, 8'h00);
    for (int c = 1; c <= 9; c++) begin
      @(posedge clk);
      @(negedge clk);
      case (c)
        1: begin
          chk("R2", "c1 marker write", longint'({mem_we, mem_re}), 2);
          chk("R2", "c1 addr", longint'(mem_addr), 0);
          chk("R2", "c1 data", longint'(mem_wdata), 8'h5A);
        end
        3: begin
          chk("R3", "c3 read strobe", longint'({mem_we, mem_re}), 1);
          chk("R3", "c3 addr", longint'(mem_addr), 0);
        end
        5: begin
          chk("R3", "c5 zero write", longint'({mem_we, mem_re}), 2);
          chk("R3", "c5 data", longint'(mem_wdata), 0);
          chk("R3", "c5 addr", longint'(mem_addr), 0);
        end
        7: chk("R3", "c7 read strobe", longint'({mem_we, mem_re}), 1);
        9: begin
          chk("R2", "c9 next marker write", longint'({mem_we, mem_re}), 2);
          chk("R2", "c9 addr", longint'(mem_addr), 1);
        end
        default: chk("R4", $sformatf("c%0d idle phase", c), longint'({mem_we, mem_re}), 0);
      endcase
    end
  endtask

  // Runs a scan to its end and checks cycle, outcome, top and the quiet tail.
  task automatic run_case(input string tag, input int size, input int faddr,
                          input logic [7:0] fmask, input int exp_top,
                          input int exp_cyc, input bit exp_halt);
    int         cyc;
    bit         quiet;
    logic [15:0] top_seen;
    start_run(size, faddr, fmask);
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done || insuff || (cyc > 40000)) break;
    end
    chk({tag, "/R4"}, "finishing edge", cyc, exp_cyc);
    chk({tag, "/R5"}, "mem_top", longint'(mem_top), exp_top);
    chk(tag, "insuff", longint'(insuff), longint'(exp_halt));
    chk(tag, "done", longint'(done), longint'(!exp_halt));
    top_seen = mem_top;
    quiet = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (mem_we || mem_re || done) quiet = 1'b0;
    end
    chk(exp_halt ? "R7" : "R8", "port quiet afterwards", longint'(quiet), 1);
    chk(exp_halt ? "R7" : "R8", "top held", longint'(mem_top), longint'(top_seen));
    chk(exp_halt ? "R7" : "R8", "insuff held", longint'(insuff), longint'(exp_halt));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    test_reset_state();
    test_first_probe();
    // R5: 2K populated, first unpopulated address 0x800 fails the marker
    run_case("R5", 2048, -1, 8'h00, 16'h07FF, 8*2048+5, 1'b0);
    // R5: marker corrupted at 0x500 (bit 0 stuck high)
    run_case("R5", 2048, 16'h0500, 8'h01, 16'h04FF, 8*16'h500+5, 1'b0);
    // R3: marker survives, zero read-back corrupted at 0x600 (bit 1 stuck high)
    run_case("R3", 2048, 16'h0600, 8'h02, 16'h05FF, 8*16'h600+9, 1'b0);
    // R6: all locations up to the limit pass
    run_case("R6", 4096, -1, 8'h00, int'(LIM), 8*int'(LIM)+9, 1'b0);
    chk("R6", "highest strobed address", max_addr, int'(LIM));
    // R9: exactly the minimum is sufficient, one short is not
    run_case("R9", MINB, -1, 8'h00, MINB-1, 8*MINB+5, 1'b0);
    run_case("R9", MINB-1, -1, 8'h00, MINB-2, 8*(MINB-1)+5, 1'b1);
    // R7: no memory at all
    run_case("R7", 0, -1, 8'h00, 16'hFFFF, 5, 1'b1);
    // R1: reset clears a halted engine
    test_reset_state();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule